// File: doc/BRIEF.md
# Reset Class Controller

This block collects every reset request a chip can raise and turns each into one of four reset classes: power-on, hard, soft and CPU-local, strongest first. Each class drives its own set of domain resets. Power-on clears test logic, core logic, the retained register domain and the CPU core. Hard spares the test logic. Soft also spares the retained registers. CPU-local resets only the CPU core. The block also produces a strobe that captures the boot configuration, a pulse that restarts boot, and an active-low status pin that marks chip-level resets.

The sources are four active-low pins (power-on, full, hard, local), watchdog timeout pulses, an emulation request and a small write-only configuration port. Watchdog, emulation and software-triggered requests each pass through a per-source hard/soft selection, which defaults to hard. The selection bits and a software CPU-local hold bit are cleared only by the power-on class, so they survive hard and soft resets.

Once a request goes away, each class keeps its domains in reset for a fixed parameter count of cycles (16 or more). All pins except power-on reach the logic through a two-flop synchroniser. The power-on pin asserts every output asynchronously and is released synchronously.

Top module: `rst_class_ctrl`

## Requirements
- R1: While `por_n` is low, all four domain resets, `stat_n`, `boot_latch` and `boot_start` are low, and they fall without waiting for a clock edge.
- R2: The power-on class (`por_n` release, or `full_n` low) drives all four domain resets low. The test reset is low only in this class. `boot_latch` is a one-cycle pulse in the cycle the domains are released, and only this class produces it.
- R3: The hard class (from `hard_n` low, or a selectable source set to hard) drives core, retained and CPU resets low and keeps the test reset high.
- R4: The soft class drives core and CPU resets low and keeps the test and retained resets high.
- R5: A write to `cfg_addr` 0 loads the selection from `cfg_wdata`. Bit 0 covers the watchdogs, bit 1 the emulation request and bit 2 the software trigger. A 1 selects soft and a 0 selects hard. After power-on every selection is hard.
- R6: A write to `cfg_addr` 2 with `cfg_wdata[0]`=1 raises a chip-level request of the software source's selected class in that same cycle.
- R7: If a request is seen for N consecutive cycles after synchronisation, its domain resets stay low for exactly N+HOLD_CYCLES cycles.
- R8: `stat_n` falls on the edge where chip-level domains assert. It rises one cycle after they are released.
- R9: `boot_start` is a single-cycle pulse on the edge where `stat_n` rises, after every power-on, hard or soft reset.
- R10: A CPU-local request drives only `cpu_rst_n` low, for N+HOLD_CYCLES cycles. It can come from `local_n` low, a `wdt_core_tmo` pulse, or bit 0 of `cfg_addr` 1 held at 1. It moves neither `stat_n` nor `boot_start`.
- R11: When requests coincide, the strongest class wins. A stronger request during a hold upgrades the class. A weaker one keeps the class and restarts the hold count.
- R12: The selection bits and the CPU-local hold bit are cleared only by the power-on class, and keep their values through hard and soft resets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on pin, active low, asynchronous |
| full_n | input | 1 | Full-reset pin, active low, power-on class |
| hard_n | input | 1 | Hard-reset pin, active low |
| local_n | input | 1 | CPU-local reset pin, active low |
| wdt_tmo | input | NUM_WDT | Watchdog timeout pulses, chip-level, selectable class |
| wdt_core_tmo | input | 1 | Watchdog timeout pulse requesting a CPU-local reset |
| emu_req | input | 1 | Emulation reset request pulse, selectable class |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration address: 0 selection, 1 local hold bit, 2 software trigger |
| cfg_wdata | input | 3 | Configuration write data |
| test_rst_n | output | 1 | Test/emulation domain reset, active low |
| core_rst_n | output | 1 | Core logic domain reset, active low |
| ret_rst_n | output | 1 | Retained register domain reset, active low |
| cpu_rst_n | output | 1 | CPU core reset, active low |
| boot_latch | output | 1 | Boot configuration capture strobe |
| boot_start | output | 1 | Boot restart pulse |
| stat_n | output | 1 | Reset status pin, active low |

## Verification
A wrong class register shows at the ports on the edge where the request is taken. The pattern across the four domain outputs names the class directly, so a swapped hard/soft selection or a lost power-on-only bit is caught within one cycle of the next selectable request. A wrong hold counter shows only at release, as a low time that differs from N+HOLD_CYCLES. The bench therefore times every release from the matching assertion. A status or boot flag derived from a stale state shows one cycle after release, as a missing, extra or misplaced `stat_n` rise or `boot_start` pulse.

// File: rtl/rcc_pkg.sv
package rcc_pkg;

  typedef enum logic [2:0] {
    RC_NONE  = 3'd0,
    RC_LOCAL = 3'd1,
    RC_SOFT  = 3'd2,
    RC_HARD  = 3'd3,
    RC_POR   = 3'd4
  } rc_class_e;

  localparam int unsigned SEL_W   = 3;
  localparam int unsigned SEL_WDT = 0;
  localparam int unsigned SEL_EMU = 1;
  localparam int unsigned SEL_SW  = 2;

  localparam logic [1:0] ADDR_SEL  = 2'd0;
  localparam logic [1:0] ADDR_LCTL = 2'd1;
  localparam logic [1:0] ADDR_TRIG = 2'd2;

  function automatic rc_class_e rc_stronger(input rc_class_e a, input rc_class_e b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic rc_is_device(input rc_class_e c);
    return (c >= RC_SOFT);
  endfunction

endpackage

// File: rtl/rcc_sync.sv
module rcc_sync #(
  parameter int unsigned    W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] s1_q;
  logic [W-1:0] s2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;

endmodule

// File: rtl/rcc_regs.sv
module rcc_regs
  import rcc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_clr,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [SEL_W-1:0] cfg_wdata,
  output logic [SEL_W-1:0] sel,
  output logic             lctl,
  output logic             sw_trig
);

  logic [SEL_W-1:0] sel_q, sel_d;
  logic             lctl_q, lctl_d;
  logic             sel_en, lctl_en;

  always_comb begin
    sel_en  = cfg_we && (cfg_addr == ADDR_SEL);
    lctl_en = cfg_we && (cfg_addr == ADDR_LCTL);
    sel_d   = sel_q;
    lctl_d  = lctl_q;
    if (por_clr) begin
      sel_d  = '0;
      lctl_d = 1'b0;
    end else begin
      if (sel_en)  sel_d  = cfg_wdata;
      if (lctl_en) lctl_d = cfg_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      lctl_q <= 1'b0;
    end else begin
      sel_q  <= sel_d;
      lctl_q <= lctl_d;
    end
  end

  assign sel     = sel_q;
  assign lctl    = lctl_q;
  assign sw_trig = cfg_we && (cfg_addr == ADDR_TRIG) && cfg_wdata[0] && !por_clr;

  AST_CFG_POR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    por_clr |=> (sel_q == '0) && !lctl_q); // R12

  AST_CFG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!por_clr && !cfg_we) |=> $stable(sel_q) && $stable(lctl_q)); // R12

endmodule

// File: rtl/rcc_arb.sv
module rcc_arb
  import rcc_pkg::*;
#(
  parameter int unsigned NUM_WDT = 2
) (
  input  logic               full_req,
  input  logic               hard_req,
  input  logic               local_req,
  input  logic [NUM_WDT-1:0] wdt_tmo,
  input  logic               wdt_core_tmo,
  input  logic               emu_req,
  input  logic               sw_trig,
  input  logic [SEL_W-1:0]   sel,
  input  logic               lctl,
  output rc_class_e          dev_cls,
  output logic               lcl_req
);

  logic [SEL_W-1:0] src_act;
  rc_class_e        prog_cls [SEL_W];

  always_comb begin
    src_act          = '0;
    src_act[SEL_WDT] = |wdt_tmo;
    src_act[SEL_EMU] = emu_req;
    src_act[SEL_SW]  = sw_trig;
  end

  for (genvar gi = 0; gi < SEL_W; gi++) begin : g_prog
    assign prog_cls[gi] = !src_act[gi] ? RC_NONE :
                          (sel[gi] ? RC_SOFT : RC_HARD);
  end

  always_comb begin
    if (full_req)      dev_cls = RC_POR;
    else if (hard_req) dev_cls = RC_HARD;
    else               dev_cls = RC_NONE;
    for (int i = 0; i < SEL_W; i++) begin
      dev_cls = rc_stronger(dev_cls, prog_cls[i]);
    end
  end

  assign lcl_req = local_req || wdt_core_tmo || lctl;

  always_comb begin
    AST_ARB_FULL_TOP: assert (!full_req || dev_cls == RC_POR); // R11
    AST_ARB_HARD_PIN: assert (!hard_req || dev_cls >= RC_HARD); // R3
  end

endmodule

// File: rtl/rcc_seq.sv
module rcc_seq
  import rcc_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  rc_class_e dev_cls,
  input  logic      lcl_req,
  output logic      test_rst_n,
  output logic      core_rst_n,
  output logic      ret_rst_n,
  output logic      cpu_rst_n,
  output logic      boot_latch,
  output logic      boot_start,
  output logic      stat_n
);

  localparam int unsigned CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] HOLD_LD = CW'(HOLD_CYCLES);

  rc_class_e     cur_q, cur_d;
  logic [CW-1:0] dcnt_q, dcnt_d;
  logic          lact_q, lact_d;
  logic [CW-1:0] lcnt_q, lcnt_d;
  logic          dev_req, dev_on_q, dev_on_d;

  logic test_q, core_q, ret_q, cpu_q, latch_q, start_q, stat_q;
  logic test_d, core_d, ret_d, cpu_d, latch_d, start_d, stat_d;

  // chip-level class and hold count
  always_comb begin
    dev_req = rc_is_device(dev_cls);
    cur_d   = cur_q;
    dcnt_d  = dcnt_q;
    if (dev_req) begin
      cur_d  = rc_stronger(cur_q, dev_cls);
      dcnt_d = HOLD_LD;
    end else if (cur_q != RC_NONE) begin
      if (dcnt_q == '0) cur_d  = RC_NONE;
      else              dcnt_d = dcnt_q - 1'b1;
    end
  end

  // CPU-local hold; a coinciding chip-level request takes precedence
  always_comb begin
    lact_d = lact_q;
    lcnt_d = lcnt_q;
    if (lcl_req && !dev_req) begin
      lact_d = 1'b1;
      lcnt_d = HOLD_LD;
    end else if (lact_q) begin
      if (lcnt_q == '0) lact_d = 1'b0;
      else              lcnt_d = lcnt_q - 1'b1;
    end
  end

  // registered outputs derived from the next state
  always_comb begin
    dev_on_q = rc_is_device(cur_q);
    dev_on_d = rc_is_device(cur_d);
    test_d   = (cur_d != RC_POR);
    core_d   = !dev_on_d;
    ret_d    = !(cur_d >= RC_HARD);
    cpu_d    = !(dev_on_d || lact_d);
    stat_d   = !(dev_on_d || dev_on_q);
    latch_d  = (cur_q == RC_POR) && (cur_d == RC_NONE);
    start_d  = !dev_on_q && !dev_on_d && !stat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q   <= RC_POR;
      dcnt_q  <= HOLD_LD;
      lact_q  <= 1'b0;
      lcnt_q  <= '0;
      test_q  <= 1'b0;
      core_q  <= 1'b0;
      ret_q   <= 1'b0;
      cpu_q   <= 1'b0;
      stat_q  <= 1'b0;
      latch_q <= 1'b0;
      start_q <= 1'b0;
    end else begin
      cur_q   <= cur_d;
      dcnt_q  <= dcnt_d;
      lact_q  <= lact_d;
      lcnt_q  <= lcnt_d;
      test_q  <= test_d;
      core_q  <= core_d;
      ret_q   <= ret_d;
      cpu_q   <= cpu_d;
      stat_q  <= stat_d;
      latch_q <= latch_d;
      start_q <= start_d;
    end
  end

  assign test_rst_n = test_q;
  assign core_rst_n = core_q;
  assign ret_rst_n  = ret_q;
  assign cpu_rst_n  = cpu_q;
  assign boot_latch = latch_q;
  assign boot_start = start_q;
  assign stat_n     = stat_q;

  AST_NEST_TEST: assert property (@(posedge clk) disable iff (!rst_n)
    !test_q |-> !ret_q); // R2
  AST_NEST_RET: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_q |-> !core_q); // R3
  AST_NEST_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    !core_q |-> !cpu_q); // R4
  AST_STAT_LATE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q) |-> $past(core_q) && !$past(core_q, 2)); // R8
  AST_LOCAL_NO_STAT: assert property (@(posedge clk) disable iff (!rst_n)
    (core_q && $past(core_q) && !cpu_q) |-> stat_q); // R10
  AST_BOOT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q); // R9
  AST_BOOT_WITH_STAT: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> $rose(stat_q)); // R9
  AST_LATCH_AT_REL: assert property (@(posedge clk) disable iff (!rst_n)
    latch_q |-> test_q && !$past(test_q)); // R2

endmodule

// File: rtl/rst_class_ctrl.sv
module rst_class_ctrl
  import rcc_pkg::*;
#(
  parameter int unsigned NUM_WDT     = 2,
  parameter int unsigned HOLD_CYCLES = 16
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               full_n,
  input  logic               hard_n,
  input  logic               local_n,
  input  logic [NUM_WDT-1:0] wdt_tmo,
  input  logic               wdt_core_tmo,
  input  logic               emu_req,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_addr,
  input  logic [2:0]         cfg_wdata,
  output logic               test_rst_n,
  output logic               core_rst_n,
  output logic               ret_rst_n,
  output logic               cpu_rst_n,
  output logic               boot_latch,
  output logic               boot_start,
  output logic               stat_n
);

  localparam int unsigned NPIN = 3;

  logic             rst_n;
  logic [NPIN-1:0]  pin_req;
  logic [SEL_W-1:0] sel;
  logic             lctl;
  logic             sw_trig;
  rc_class_e        dev_cls;
  logic             lcl_req;

  rcc_sync #(.W(1), .RST_VAL(1'b0)) u_por_sync (
    .clk    (clk),
    .arst_n (por_n),
    .d      (1'b1),
    .q      (rst_n)
  );

  rcc_sync #(.W(NPIN), .RST_VAL('0)) u_pin_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .d      ({~local_n, ~hard_n, ~full_n}),
    .q      (pin_req)
  );

  rcc_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .por_clr   (pin_req[0]),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .sel       (sel),
    .lctl      (lctl),
    .sw_trig   (sw_trig)
  );

  rcc_arb #(.NUM_WDT(NUM_WDT)) u_arb (
    .full_req     (pin_req[0]),
    .hard_req     (pin_req[1]),
    .local_req    (pin_req[2]),
    .wdt_tmo      (wdt_tmo),
    .wdt_core_tmo (wdt_core_tmo),
    .emu_req      (emu_req),
    .sw_trig      (sw_trig),
    .sel          (sel),
    .lctl         (lctl),
    .dev_cls      (dev_cls),
    .lcl_req      (lcl_req)
  );

  rcc_seq #(.HOLD_CYCLES(HOLD_CYCLES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .dev_cls    (dev_cls),
    .lcl_req    (lcl_req),
    .test_rst_n (test_rst_n),
    .core_rst_n (core_rst_n),
    .ret_rst_n  (ret_rst_n),
    .cpu_rst_n  (cpu_rst_n),
    .boot_latch (boot_latch),
    .boot_start (boot_start),
    .stat_n     (stat_n)
  );

endmodule

// File: tb/sim_rst_class_ctrl.sv
module sim_rst_class_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 16;
  localparam int NW   = 2;

  // observed vector: {test, core, ret, cpu, stat, latch, start}
  localparam logic [6:0] V_POR   = 7'b0000000;
  localparam logic [6:0] V_HARD  = 7'b1000000;
  localparam logic [6:0] V_SOFT  = 7'b1010000;
  localparam logic [6:0] V_LOCAL = 7'b1110100;
  localparam logic [6:0] V_RELP  = 7'b1111010;
  localparam logic [6:0] V_REL   = 7'b1111000;
  localparam logic [6:0] V_START = 7'b1111101;
  localparam logic [6:0] V_IDLE  = 7'b1111100;

  logic clk = 1'b0;
  logic por_n, full_n, hard_n, local_n, wdt_core_tmo, emu_req, cfg_we;
  logic [NW-1:0] wdt_tmo;
  logic [1:0] cfg_addr;
  logic [2:0] cfg_wdata;
  logic test_rst_n, core_rst_n, ret_rst_n, cpu_rst_n, boot_latch, boot_start, stat_n;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_cyc = 0;
  logic mon_on = 1'b0;
  logic [6:0] prev_v = 7'b0;
  logic [6:0] qv[$];
  int         qd[$];
  string      qr[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_class_ctrl #(.NUM_WDT(NW), .HOLD_CYCLES(HOLD)) u0 (
    .clk(clk), .por_n(por_n), .full_n(full_n), .hard_n(hard_n), .local_n(local_n),
    .wdt_tmo(wdt_tmo), .wdt_core_tmo(wdt_core_tmo), .emu_req(emu_req),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .test_rst_n(test_rst_n), .core_rst_n(core_rst_n), .ret_rst_n(ret_rst_n),
    .cpu_rst_n(cpu_rst_n), .boot_latch(boot_latch), .boot_start(boot_start),
    .stat_n(stat_n)
  );

  function automatic logic [6:0] obs();
    return {test_rst_n, core_rst_n, ret_rst_n, cpu_rst_n, stat_n, boot_latch, boot_start};
  endfunction

  task automatic chk(input logic ok, input string req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic push(input logic [6:0] v, input int dt, input string req);
    qv.push_back(v); qd.push_back(dt); qr.push_back(req);
  endtask

  task automatic dev_seq(input logic [6:0] pat, input int n, input logic por, input string req);
    push(pat, -1, req);
    push(por ? V_RELP : V_REL, n + HOLD, req);
    push(V_START, 1, "R9");
    push(V_IDLE, 1, "R9");
  endtask

  // monitor: pops one expected item per change of the output vector
  always @(negedge clk) begin
    if (mon_on) begin
      logic [6:0] cur;
      cyc++;
      cur = obs();
      if (cur !== prev_v) begin
        checks++;
        if (qv.size() == 0) begin
          errors++;
          $display("FAIL R11: unexpected change act=%b exp=%b", cur, prev_v);
        end else begin
          logic [6:0] ev;
          int d;
          string r;
          ev = qv.pop_front(); d = qd.pop_front(); r = qr.pop_front();
          if (cur !== ev || (d >= 0 && (cyc - last_cyc) != d)) begin
            errors++;
            $display("FAIL %s: act=%b dt=%0d exp=%b dt=%0d", r, cur, cyc - last_cyc, ev, d);
          end
        end
        last_cyc = cyc;
        prev_v = cur;
      end
    end
  end

  task automatic settle();
    repeat (HOLD + 20) @(negedge clk);
  endtask

  task automatic cfg_wr(input logic [1:0] a, input logic [2:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_wdt(input int idx);
    wdt_tmo[idx] = 1'b1;
    @(negedge clk);
    wdt_tmo = '0;
  endtask

  task automatic pulse_emu();
    emu_req = 1'b1;
    @(negedge clk);
    emu_req = 1'b0;
  endtask

  task automatic hard_pin(input int n);
    hard_n = 1'b0;
    repeat (n) @(negedge clk);
    hard_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog: act=running exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    por_n = 1'b0; full_n = 1'b1; hard_n = 1'b1; local_n = 1'b1;
    wdt_tmo = '0; wdt_core_tmo = 1'b0; emu_req = 1'b0;
    cfg_we = 1'b0; cfg_addr = 2'd0; cfg_wdata = 3'd0;
    repeat (3) @(negedge clk);
    chk(obs() == 7'b0, "R1", obs(), 7'b0);

    // power-on release
    push(V_RELP, -1, "R2"); push(V_START, 1, "R9"); push(V_IDLE, 1, "R9");
    mon_on = 1'b1;
    por_n = 1'b1;
    settle();

    // hard pin, default-hard selectable sources
    dev_seq(V_HARD, 3, 1'b0, "R3"); hard_pin(3); settle();
    dev_seq(V_HARD, 1, 1'b0, "R5"); pulse_wdt(1); settle();
    dev_seq(V_HARD, 1, 1'b0, "R5"); pulse_emu(); settle();
    dev_seq(V_HARD, 1, 1'b0, "R6"); cfg_wr(2'd2, 3'b001); settle();

    // all selectable sources to soft
    cfg_wr(2'd0, 3'b111);
    repeat (3) @(negedge clk);
    dev_seq(V_SOFT, 1, 1'b0, "R4"); pulse_wdt(0); settle();
    dev_seq(V_SOFT, 1, 1'b0, "R5"); pulse_emu(); settle();
    dev_seq(V_SOFT, 1, 1'b0, "R6"); cfg_wr(2'd2, 3'b001); settle();

    // selection survives a hard reset
    dev_seq(V_HARD, 2, 1'b0, "R12"); hard_pin(2); settle();
    dev_seq(V_SOFT, 1, 1'b0, "R12"); pulse_wdt(0); settle();

    // watchdog soft, emulation hard: simultaneous -> hard
    cfg_wr(2'd0, 3'b001);
    repeat (3) @(negedge clk);
    dev_seq(V_HARD, 1, 1'b0, "R11");
    wdt_tmo[0] = 1'b1; emu_req = 1'b1;
    @(negedge clk);
    wdt_tmo = '0; emu_req = 1'b0;
    settle();

    // upgrade soft -> hard during hold
    push(V_SOFT, -1, "R11"); push(V_HARD, -1, "R11");
    push(V_REL, -1, "R11"); push(V_START, 1, "R9"); push(V_IDLE, 1, "R9");
    pulse_wdt(0);
    repeat (4) @(negedge clk);
    hard_pin(2);
    settle();

    // weaker request during hard hold keeps class, restarts count
    push(V_HARD, -1, "R11"); push(V_REL, HOLD + 3, "R7");
    push(V_START, 1, "R9"); push(V_IDLE, 1, "R9");
    hard_pin(2);
    repeat (2) @(negedge clk);
    pulse_wdt(0);
    settle();

    // CPU-local sources
    push(V_LOCAL, -1, "R10"); push(V_IDLE, 2 + HOLD, "R10");
    local_n = 1'b0; repeat (2) @(negedge clk); local_n = 1'b1;
    settle();
    push(V_LOCAL, -1, "R10"); push(V_IDLE, 1 + HOLD, "R10");
    wdt_core_tmo = 1'b1; @(negedge clk); wdt_core_tmo = 1'b0;
    settle();
    push(V_LOCAL, -1, "R10"); push(V_IDLE, 5 + HOLD, "R7");
    cfg_wr(2'd1, 3'b001);
    repeat (4) @(negedge clk);
    cfg_wr(2'd1, 3'b000);
    settle();

    // local hold bit survives a hard reset
    push(V_LOCAL, -1, "R10"); push(V_HARD, -1, "R3");
    push(7'b1110000, 2 + HOLD, "R12"); push(7'b1110101, 1, "R9");
    push(V_LOCAL, 1, "R12"); push(V_IDLE, -1, "R12");
    cfg_wr(2'd1, 3'b001);
    repeat (4) @(negedge clk);
    hard_pin(2);
    settle();
    cfg_wr(2'd1, 3'b000);
    settle();

    // full pin: power-on class, clears the selection
    dev_seq(V_POR, 2, 1'b1, "R2");
    full_n = 1'b0; repeat (2) @(negedge clk); full_n = 1'b1;
    settle();
    dev_seq(V_HARD, 1, 1'b0, "R12"); pulse_wdt(0); settle();

    // asynchronous power-on assertion mid-cycle
    push(V_POR, -1, "R1");
    @(posedge clk);
    #2 por_n = 1'b0;
    #1 chk(obs() == 7'b0, "R1", obs(), 7'b0);
    repeat (3) @(negedge clk);
    push(V_RELP, -1, "R2"); push(V_START, 1, "R9"); push(V_IDLE, 1, "R9");
    por_n = 1'b1;
    settle();

    chk(qv.size() == 0, "R8", 7'(qv.size()), 7'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule